// File: doc/BRIEF.md
# DMA Status Counters and Interrupt Combiner

This block holds the status for the transmit and receive directions of a packet DMA and folds it into a single interrupt request. Each direction keeps an 8-bit count of completed packets and a packet flag. Each direction also keeps one sticky error flag: underrun for transmit, overflow for receive. Single-cycle event pulses from the descriptor engines raise the counts and flags. Software acknowledges completed packets one at a time by writing a 1 to the packet flag bit. Each such write takes one off the count, so the packet flag stays up until every counted packet has been acknowledged.

An 8-bit mask selects which status bits may raise the interrupt. A read-only register shows the masked vector. The interrupt output is a registered OR of that vector. The block also holds the receive DMA enable bit, which a receive overflow event forces low. The register port is a plain write strobe with a separate combinational read address, and the event inputs are plain pulses, so the block needs no handshake. Registers sit at byte addresses that are multiples of four, and address bits [1:0] are ignored.

Top module: `dsi_dma_status_irq`

## Requirements
- R1: After reset, every register reads 0, and both `rx_dma_en` and `irq` are low.
- R2: A packet event pulse adds one to its direction's count in status bits [23:16], wrapping modulo 256, and sets status bit 0. Transmit status is at 0x00 and receive status is at 0x04.
- R3: Writing 1 to bit 0 of a status register takes one off the count, wrapping from 0 to 255. Bit 0 clears only when the new count is zero; otherwise it keeps its value.
- R4: The transmit underrun flag (0x00 bit 1) and the receive overflow flag (0x04 bit 2) are set by their event pulses and cleared by writing 1 to the same bit. A set and a clear in the same cycle leave the flag set.
- R5: A packet event and a decrement write to the same direction in the same cycle leave the count unchanged, and bit 0 then reads 1 exactly when that count is nonzero.
- R6: The register at 0x0C reads the mask ANDed with the vector {receive status[3:0], transmit status[3:0]} in bits [7:0], with zeros above. Writes to 0x0C change nothing.
- R7: The mask register at 0x08 stores write bits [7:0]. Its bits [31:8] read 0.
- R8: `irq` is registered. It is high exactly when the masked vector was nonzero in the previous cycle.
- R9: Bit 0 of the register at 0x10 is the receive DMA enable and drives `rx_dma_en`. A receive overflow event clears it, and takes priority over a write of 1 in the same cycle.
- R10: Reads of unmapped addresses (0x14 to 0x1C) return 0. Status bits outside the count, bit 0 and the direction's sticky flag always read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (5) | Byte address of the write |
| wr_data | input | DATA_W (32) | Write data |
| rd_addr | input | ADDR_W (5) | Byte address of the combinational read |
| rd_data | output | DATA_W (32) | Read data for `rd_addr` |
| tx_pkt_evt | input | 1 | Pulse: one transmit packet completed |
| tx_urun_evt | input | 1 | Pulse: transmit underrun |
| rx_pkt_evt | input | 1 | Pulse: one receive packet completed |
| rx_ovfl_evt | input | 1 | Pulse: receive overflow |
| rx_dma_en | output | 1 | Receive DMA enable |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench targets the cycle where a packet event and an acknowledge write meet. A design that applied only one of the two would move the count up or down. The bench also covers a decrement that leaves a nonzero count, where a design that cleared bit 0 at once would drop pending packets from the interrupt. Counter wrap is driven in both directions: 256 events give a zero count with the flag still set, and one acknowledge from zero gives 255. An overflow event that coincides with a write re-enabling receive must leave the enable low, and an overflow that coincides with its clear write must leave the flag set. The one-cycle lag of `irq` is measured on both its rise and its fall, so a combinational or doubly registered output shows up. The nibble placement in the masked register is checked, as is the fact that writes to it are ignored.

// File: rtl/dsi_pkg.sv
`timescale 1ns/1ps
package dsi_pkg;
  localparam int unsigned NUM_DIR   = 2;
  localparam int unsigned NIB_W     = 4;
  localparam int unsigned PKT_BIT   = 0;
  // word indices (byte address >> 2)
  localparam int unsigned W_TX_STAT = 0;
  localparam int unsigned W_RX_STAT = 1;
  localparam int unsigned W_MASK    = 2;
  localparam int unsigned W_IRQ     = 3;
  localparam int unsigned W_RX_CTL  = 4;

  typedef enum logic [0:0] {DIR_TX = 1'b0, DIR_RX = 1'b1} dir_e;

  // bit holding the sticky error flag of a direction
  function automatic int unsigned sticky_bit(input int unsigned dir);
    return (dir == int'(DIR_TX)) ? 1 : 2;
  endfunction

  // status word index of a direction
  function automatic int unsigned stat_word(input int unsigned dir);
    return (dir == int'(DIR_TX)) ? W_TX_STAT : W_RX_STAT;
  endfunction
endpackage

// File: rtl/dsi_pkt_counter.sv
`timescale 1ns/1ps
module dsi_pkt_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             flag
);
  logic [CNT_W-1:0] cnt_dn;
  assign cnt_dn = cnt - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else begin
      case ({inc, dec})
        2'b10: begin
          cnt  <= cnt + CNT_W'(1);
          flag <= 1'b1;
        end
        2'b01: begin
          cnt <= cnt_dn;
          if (cnt_dn == '0) flag <= 1'b0;
        end
        2'b11: flag <= (cnt != '0);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dsi_event_bit.sv
`timescale 1ns/1ps
module dsi_event_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end
endmodule

// File: rtl/dsi_irq_gen.sv
`timescale 1ns/1ps
module dsi_irq_gen #(
  parameter int unsigned VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VEC_W-1:0] raw,
  input  logic [VEC_W-1:0] mask,
  output logic [VEC_W-1:0] masked,
  output logic             irq
);
  assign masked = raw & mask;

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |masked;
  end
endmodule

// File: rtl/dsi_dma_status_irq.sv
`timescale 1ns/1ps
module dsi_dma_status_irq
  import dsi_pkg::*;
#(
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned CNT_LSB = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              tx_pkt_evt,
  input  logic              tx_urun_evt,
  input  logic              rx_pkt_evt,
  input  logic              rx_ovfl_evt,
  output logic              rx_dma_en,
  output logic              irq
);
  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam int unsigned VEC_W  = NIB_W * NUM_DIR;

  logic [WORD_W-1:0] wr_word, rd_word;
  assign wr_word = wr_addr[ADDR_W-1:2];
  assign rd_word = rd_addr[ADDR_W-1:2];

  logic [NUM_DIR-1:0]             pkt_evt, stk_evt;
  logic [NUM_DIR-1:0][CNT_W-1:0]  cnt_q;
  logic [NUM_DIR-1:0]             flag_q, stk_q;
  logic [NUM_DIR-1:0][DATA_W-1:0] stat_w;
  logic [VEC_W-1:0]               raw_vec, mask_q, masked_vec;

  assign pkt_evt = {rx_pkt_evt, tx_pkt_evt};
  assign stk_evt = {rx_ovfl_evt, tx_urun_evt};

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    localparam int unsigned SB = sticky_bit(d);
    logic hit, dec, clr;
    assign hit = wr_en && (wr_word == WORD_W'(stat_word(d)));
    assign dec = hit && wr_data[PKT_BIT];
    assign clr = hit && wr_data[SB];

    dsi_pkt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk (clk), .rst_n(rst_n), .inc(pkt_evt[d]), .dec(dec),
      .cnt (cnt_q[d]), .flag(flag_q[d])
    );

    dsi_event_bit u_stk (
      .clk(clk), .rst_n(rst_n), .set(stk_evt[d]), .clr(clr), .q(stk_q[d])
    );

    assign stat_w[d] = (DATA_W'(cnt_q[d]) << CNT_LSB)
                     | (DATA_W'(stk_q[d]) << SB)
                     | (DATA_W'(flag_q[d]) << PKT_BIT);
    assign raw_vec[d*NIB_W +: NIB_W] = stat_w[d][NIB_W-1:0];
  end

  // mask register
  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= '0;
    else if (wr_en && wr_word == WORD_W'(W_MASK)) mask_q <= wr_data[VEC_W-1:0];
  end

  // receive enable; overflow wins over a write
  always_ff @(posedge clk) begin
    if (!rst_n)           rx_dma_en <= 1'b0;
    else if (rx_ovfl_evt) rx_dma_en <= 1'b0;
    else if (wr_en && wr_word == WORD_W'(W_RX_CTL)) rx_dma_en <= wr_data[0];
  end

  dsi_irq_gen #(.VEC_W(VEC_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .raw(raw_vec), .mask(mask_q),
    .masked(masked_vec), .irq(irq)
  );

  always_comb begin
    rd_data = '0;
    case (rd_word)
      WORD_W'(W_TX_STAT): rd_data = stat_w[DIR_TX];
      WORD_W'(W_RX_STAT): rd_data = stat_w[DIR_RX];
      WORD_W'(W_MASK):    rd_data = DATA_W'(mask_q);
      WORD_W'(W_IRQ):     rd_data = DATA_W'(masked_vec);
      WORD_W'(W_RX_CTL):  rd_data = DATA_W'(rx_dma_en);
      default:            rd_data = '0;
    endcase
  end
endmodule

// File: rtl/dsi_dma_status_irq_chk.sv
`timescale 1ns/1ps
module dsi_dma_status_irq_chk
  import dsi_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          wr_en,
  input logic [ADDR_W-1:0]             wr_addr,
  input logic [DATA_W-1:0]             wr_data,
  input logic                          tx_pkt_evt,
  input logic                          tx_urun_evt,
  input logic                          rx_ovfl_evt,
  input logic                          rx_dma_en,
  input logic                          irq,
  input logic [NUM_DIR-1:0][CNT_W-1:0] cnt,
  input logic [NUM_DIR-1:0]            flag,
  input logic [NUM_DIR-1:0]            stk,
  input logic [NIB_W*NUM_DIR-1:0]      mask
);
  logic tx_dec;
  assign tx_dec = wr_en && (wr_addr[ADDR_W-1:2] == (ADDR_W-2)'(W_TX_STAT)) && wr_data[0];

  a_r2_pkt_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pkt_evt && !tx_dec) |=> flag[0]);

  a_r3_flag_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_dec && !tx_pkt_evt && cnt[0] != CNT_W'(1)) |=> $stable(flag[0]));

  a_r4_urun_set: assert property (@(posedge clk) disable iff (!rst_n)
    tx_urun_evt |=> stk[0]);

  a_r5_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pkt_evt && tx_dec) |=> (cnt[0] == $past(cnt[0])));

  a_r8_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mask) == '0) |-> !irq);

  a_r9_ovfl_clears_en: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovfl_evt |=> !rx_dma_en);
endmodule

bind dsi_dma_status_irq dsi_dma_status_irq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .tx_pkt_evt(tx_pkt_evt), .tx_urun_evt(tx_urun_evt), .rx_ovfl_evt(rx_ovfl_evt),
  .rx_dma_en(rx_dma_en), .irq(irq), .cnt(cnt_q), .flag(flag_q), .stk(stk_q),
  .mask(mask_q)
);

// File: tb/dsi_dma_status_irq_bench.sv
`timescale 1ns/1ps
module dsi_dma_status_irq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        tx_pkt_evt = 1'b0, tx_urun_evt = 1'b0;
  logic        rx_pkt_evt = 1'b0, rx_ovfl_evt = 1'b0;
  logic        rx_dma_en, irq;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  dsi_dma_status_irq u_dsi_dma_status_irq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tx_pkt_evt(tx_pkt_evt),
    .tx_urun_evt(tx_urun_evt), .rx_pkt_evt(rx_pkt_evt), .rx_ovfl_evt(rx_ovfl_evt),
    .rx_dma_en(rx_dma_en), .irq(irq)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        txp, txu, rxp, rxo, we;
    logic [4:0]  wa;
    logic [31:0] wd;
    logic [31:0] etx;
    logic [31:0] erx;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{4'd2,  1'b1,1'b0,1'b0,1'b0,1'b0, 5'h00, 32'h0,          32'h0001_0001, 32'h0},           // R2
    '{4'd2,  1'b1,1'b0,1'b0,1'b0,1'b0, 5'h00, 32'h0,          32'h0002_0001, 32'h0},           // R2
    '{4'd4,  1'b0,1'b1,1'b1,1'b0,1'b0, 5'h00, 32'h0,          32'h0002_0003, 32'h0001_0001},   // R4
    '{4'd3,  1'b0,1'b0,1'b0,1'b0,1'b1, 5'h00, 32'h1,          32'h0001_0003, 32'h0001_0001},   // R3
    '{4'd4,  1'b0,1'b0,1'b0,1'b0,1'b1, 5'h00, 32'h2,          32'h0001_0001, 32'h0001_0001},   // R4
    '{4'd5,  1'b1,1'b0,1'b0,1'b0,1'b1, 5'h00, 32'h1,          32'h0001_0001, 32'h0001_0001},   // R5
    '{4'd3,  1'b0,1'b0,1'b0,1'b0,1'b1, 5'h00, 32'h1,          32'h0,          32'h0001_0001},  // R3
    '{4'd4,  1'b0,1'b0,1'b0,1'b1,1'b0, 5'h00, 32'h0,          32'h0,          32'h0001_0005},  // R4
    '{4'd4,  1'b0,1'b0,1'b0,1'b0,1'b1, 5'h04, 32'h4,          32'h0,          32'h0001_0001},  // R4
    '{4'd3,  1'b0,1'b0,1'b0,1'b0,1'b1, 5'h04, 32'h5,          32'h0,          32'h0},          // R3
    '{4'd4,  1'b0,1'b0,1'b0,1'b1,1'b1, 5'h04, 32'h4,          32'h0,          32'h0000_0004},  // R4
    '{4'd10, 1'b0,1'b0,1'b0,1'b0,1'b1, 5'h04, 32'h8000_0004,  32'h0,          32'h0}           // R10
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    rd_addr = a;
    #0.2;
    d = rd_data;
  endtask

  // inputs change just after a rising edge, hold one cycle
  task automatic cyc();
    @(posedge clk);
    #1;
    wr_en = 1'b0; tx_pkt_evt = 1'b0; tx_urun_evt = 1'b0;
    rx_pkt_evt = 1'b0; rx_ovfl_evt = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    do_reset();

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(5'(a * 4), d);
      check("R1 reset register", d, 32'h0);
    end
    check("R1 irq after reset", {31'h0, irq}, 32'h0);
    check("R1 rx_dma_en after reset", {31'h0, rx_dma_en}, 32'h0);

    // R10 unmapped reads
    rd(5'h14, d); check("R10 unmapped 0x14", d, 32'h0);
    rd(5'h1C, d); check("R10 unmapped 0x1C", d, 32'h0);

    // vector table
    for (int i = 0; i < 12; i++) begin
      tx_pkt_evt = VECS[i].txp; tx_urun_evt = VECS[i].txu;
      rx_pkt_evt = VECS[i].rxp; rx_ovfl_evt = VECS[i].rxo;
      wr_en = VECS[i].we; wr_addr = VECS[i].wa; wr_data = VECS[i].wd;
      cyc();
      rd(5'h00, d); check($sformatf("R%0d vector %0d tx status", VECS[i].req, i), d, VECS[i].etx);
      rd(5'h04, d); check($sformatf("R%0d vector %0d rx status", VECS[i].req, i), d, VECS[i].erx);
    end

    // R7 mask width
    wr(5'h08, 32'hFFFF_FF01);
    rd(5'h08, d); check("R7 mask readback", d, 32'h0000_0001);

    // R6 write to masked register ignored
    wr(5'h0C, 32'hFFFF_FFFF);
    rd(5'h08, d); check("R6 mask untouched by 0x0C write", d, 32'h1);
    rd(5'h0C, d); check("R6 masked reg unchanged", d, 32'h0);

    // R8 irq latency: event -> status -> irq
    tx_pkt_evt = 1'b1;
    cyc();
    rd(5'h0C, d); check("R6 masked vector tx bit", d, 32'h0000_0001);
    check("R8 irq not yet high", {31'h0, irq}, 32'h0);
    cyc();
    check("R8 irq high one cycle later", {31'h0, irq}, 32'h1);
    wr(5'h08, 32'h0);
    check("R8 irq still high right after unmask", {31'h0, irq}, 32'h1);
    cyc();
    check("R8 irq low one cycle later", {31'h0, irq}, 32'h0);

    // R9 receive enable
    wr(5'h10, 32'h1);
    check("R9 rx_dma_en set", {31'h0, rx_dma_en}, 32'h1);
    rd(5'h10, d); check("R9 rx control readback", d, 32'h1);
    rx_ovfl_evt = 1'b1;
    cyc();
    check("R9 overflow clears enable", {31'h0, rx_dma_en}, 32'h0);

    // R6 receive nibble placement (rx status now 0x4)
    wr(5'h08, 32'hF0);
    rd(5'h0C, d); check("R6 rx overflow lands in bit 6", d, 32'h0000_0040);

    // R9 overflow beats same-cycle enable write
    rx_ovfl_evt = 1'b1; wr_en = 1'b1; wr_addr = 5'h10; wr_data = 32'h1;
    cyc();
    check("R9 overflow over write", {31'h0, rx_dma_en}, 32'h0);

    // R2 / R3 wrap
    do_reset();
    tx_pkt_evt = 1'b1;
    repeat (255) @(posedge clk);
    cyc();
    rd(5'h00, d); check("R2 count wraps to 0 with flag set", d, 32'h0000_0001);
    wr(5'h00, 32'h1);
    rd(5'h00, d); check("R3 decrement from 0 wraps, flag kept", d, 32'h00FF_0001);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule